// File: doc/BRIEF.md
# Programmable prescaled down-counter timer

This block is a single countdown timer controlled through a small word-addressed register window with plain read and write strobes. A synchronous tick enable advances it, optionally divided by 16 or 256 by an internal prescaler. The counter runs at a 16-bit or 32-bit width. It can run in one of three modes: free-running (wraps to the all-ones value of the selected width), periodic (reloads from a stored load value) or one-shot (stops at zero). Each expiry sets a sticky raw interrupt flag. The flag is masked by an enable bit to drive one level-sensitive interrupt line.

Software loads the counter in one of two ways. An immediate load reloads the running count at once. A background load only updates the stored value, which takes effect at the next periodic reload. Read data is combinational from the registers while the read strobe is high and is zero otherwise.

Top module: `pdt_timer`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable set, timer stopped, free-running, 16-bit, divide by 1), and the count, the stored load value, raw status and `irq` are all 0.
- R2: Control at offset 0x08 uses bit 7 = enable, bit 6 = periodic, bit 5 = interrupt enable, bits 3:2 = prescale, bit 1 = 32-bit width, bit 0 = one-shot; bit 4 and bits 31:8 read 0. The count changes only on a prescaled tick while enabled, or on an immediate load.
- R3: A write to offset 0x00 stores the value and sets the count to it in the next cycle, truncated to the selected width.
- R4: A write to offset 0x18 stores the value without changing the count; reads of 0x00 and 0x18 both return the stored value.
- R5: An expiry is a prescaled tick while the count is 1. In periodic mode the count becomes the stored value; in free-running mode it becomes 0xFFFF or 0xFFFFFFFF by width. A tick at count 0 outside one-shot mode reloads the same way without an expiry.
- R6: In one-shot mode (bit 0) an expiry leaves the count at 0, and further ticks keep it at 0 with no new expiry.
- R7: An expiry sets the raw flag, read as bit 0 of offset 0x10; any write to offset 0x0C clears it.
- R8: `irq` and bit 0 of offset 0x14 equal the raw flag ANDed with the interrupt enable bit.
- R9: Writes to offset 0x04 are ignored; reads of 0x0C and of unmapped offsets return 0; `rdata` is 0 while `rd_en` is low.
- R10: Prescale code 01 divides the tick enable by 16, 10 by 256, and 00 and 11 by 1. The divider restarts on every control write, so the first prescaled tick comes on the Nth tick enable after that write.
- R11: In 16-bit mode the count reads with bits 31:16 at 0, while the stored load value keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick, synchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count shows on the next read of offset 0x04, and a wrong reload value shows one prescaled tick after the count reaches 1. A prescaler that is out of phase moves every decrement by whole tick periods, so a read one tick before and one tick after the expected step exposes it at once. A raw flag or mask that is stuck shows on `irq` in the cycle after the expiry or the write that should change it, and also in status reads 0x10 and 0x14.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int PW = 8;

    localparam logic [AW-1:0] OFS_LOAD   = 5'h00;
    localparam logic [AW-1:0] OFS_COUNT  = 5'h04;
    localparam logic [AW-1:0] OFS_CTRL   = 5'h08;
    localparam logic [AW-1:0] OFS_ICLR   = 5'h0C;
    localparam logic [AW-1:0] OFS_RAW    = 5'h10;
    localparam logic [AW-1:0] OFS_MIS    = 5'h14;
    localparam logic [AW-1:0] OFS_BGLOAD = 5'h18;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_16  = 2'b01,
        DIV_256 = 2'b10,
        DIV_RSV = 2'b11
    } div_e;

    // bit positions are software-visible
    typedef struct packed {
        logic run;       // 7
        logic periodic;  // 6
        logic ien;       // 5
        logic rsv4;      // 4
        div_e div;       // 3:2
        logic wide;      // 1
        logic oneshot;   // 0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b0, periodic: 1'b0, ien: 1'b1,
                                   rsv4: 1'b0, div: DIV_1, wide: 1'b0,
                                   oneshot: 1'b0};

    function automatic logic [DW-1:0] width_mask(input logic wide);
        return wide ? {DW{1'b1}} : {{(DW-16){1'b0}}, 16'hFFFF};
    endfunction

    function automatic logic [PW-1:0] div_last(input div_e d);
        case (d)
            DIV_16:  return PW'(15);
            DIV_256: return PW'(255);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler
    import pdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick_en,
    input  div_e div,
    output logic ptick
);
    logic [PW-1:0] phase_q;

    assign ptick = tick_en && !restart && (phase_q == div_last(div));

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase_q <= '0;
        else if (tick_en)
            phase_q <= ptick ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
    import pdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          ptick,
    input  logic          load_now,
    input  logic [DW-1:0] load_in,
    input  logic [DW-1:0] reload_src,
    output logic [DW-1:0] count,
    output logic          expire
);
    logic [DW-1:0] cnt_q, cnt_d, mask, cur, wrap_val;

    assign mask     = width_mask(ctrl.wide);
    assign cur      = cnt_q & mask;
    assign count    = cur;
    assign wrap_val = ctrl.periodic ? (reload_src & mask) : mask;

    always_comb begin
        cnt_d  = cur;
        expire = 1'b0;
        if (load_now) begin
            cnt_d = load_in & mask;
        end else if (ctrl.run && ptick) begin
            if (cur == DW'(1)) begin
                expire = 1'b1;
                cnt_d  = ctrl.oneshot ? '0 : wrap_val;
            end else if (cur == '0) begin
                cnt_d  = ctrl.oneshot ? '0 : wrap_val;
            end else begin
                cnt_d  = cur - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
    import pdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count,
    input  logic          expire,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] load_q,
    output logic          load_now,
    output logic          ctrl_wr,
    output logic          raw_flag,
    output logic          irq
);
    logic bg_wr, clr_wr;

    assign load_now = wr_en && (addr == OFS_LOAD);
    assign bg_wr    = wr_en && (addr == OFS_BGLOAD);
    assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
    assign clr_wr   = wr_en && (addr == OFS_ICLR);
    assign irq      = raw_flag && ctrl_q.ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            load_q   <= '0;
            raw_flag <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_t'({wdata[7:5], 1'b0, wdata[3:0]});
            if (load_now || bg_wr)
                load_q <= wdata;
            if (expire)
                raw_flag <= 1'b1;
            else if (clr_wr)
                raw_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_LOAD, OFS_BGLOAD: rdata = load_q;
                OFS_COUNT:            rdata = count;
                OFS_CTRL:             rdata = {{(DW-8){1'b0}}, ctrl_q};
                OFS_RAW:              rdata = {{(DW-1){1'b0}}, raw_flag};
                OFS_MIS:              rdata = {{(DW-1){1'b0}}, irq};
                default:              rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] load_q, count_val;
    logic          load_now, ctrl_wr, raw_flag, expire, ptick;

    pdt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .count(count_val), .expire(expire), .rdata(rdata),
        .ctrl_q(ctrl_q), .load_q(load_q), .load_now(load_now),
        .ctrl_wr(ctrl_wr), .raw_flag(raw_flag), .irq(irq)
    );

    pdt_prescaler u_presc (
        .clk(clk), .rst(rst), .restart(ctrl_wr), .tick_en(tick_en),
        .div(ctrl_q.div), .ptick(ptick)
    );

    pdt_counter u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .ptick(ptick),
        .load_now(load_now), .load_in(wdata), .reload_src(load_q),
        .count(count_val), .expire(expire)
    );
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
    import pdt_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          irq,
    input ctrl_t         ctrl_q,
    input logic [DW-1:0] count_val,
    input logic          expire,
    input logic          ptick,
    input logic          raw_flag
);
    logic [DW-1:0] msk;
    assign msk = ctrl_q.wide ? {DW{1'b1}} : {{(DW-16){1'b0}}, 16'hFFFF};

    a_r3_load_immediate: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_LOAD) |=> count_val == ($past(wdata) & msk));

    a_r4_bg_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_BGLOAD && !(ctrl_q.run && ptick)) |=> $stable(count_val));

    a_r9_count_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_COUNT && !(ctrl_q.run && ptick)) |=> $stable(count_val));

    a_r2_no_tick_no_step: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_q.run && ptick) && !(wr_en && (addr == OFS_LOAD || addr == OFS_CTRL)))
        |=> $stable(count_val));

    a_r6_oneshot_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.oneshot && count_val == '0 && !wr_en) |=> count_val == '0);

    a_r7_expire_sets: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw_flag);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_ICLR && !expire) |=> !raw_flag);

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(expire) || $past(wr_en && addr == OFS_CTRL)));
endmodule

bind pdt_timer pdt_checker i_pdt_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .ctrl_q(ctrl_q), .count_val(count_val), .expire(expire),
    .ptick(ptick), .raw_flag(raw_flag)
);

// File: tb/test_pdt_timer.sv
`timescale 1ns/100ps
module test_pdt_timer;
    localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                           A_ICLR = 5'h0C, A_RAW = 5'h10, A_MIS = 5'h14,
                           A_BG = 5'h18;

    logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int probe = 0;              // 0 none, 1 rdata, 2 irq

    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;     // 200 MHz

    pdt_timer i_pdt_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: samples mid low phase, pops expected items
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (probe != 0 && q_exp.size() > 0) begin
                logic [31:0] e, act;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                act = (probe == 2) ? {31'b0, irq} : rdata;
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: got 0x%08h expected 0x%08h", t, act, e);
                end
            end
        end
    end

    task automatic idle_set();
        tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; probe = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); idle_set(); wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); idle_set(); tick_en = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); idle_set();
        end
    endtask

    task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string t);
        @(negedge clk); idle_set(); rd_en = 1'b1; addr = a; probe = 1;
        q_exp.push_back(e); q_tag.push_back(t);
    endtask

    task automatic exp_nord(input logic [4:0] a, input string t);
        @(negedge clk); idle_set(); addr = a; probe = 1;
        q_exp.push_back(32'h0); q_tag.push_back(t);
    endtask

    task automatic exp_irq(input logic e, input string t);
        @(negedge clk); idle_set(); probe = 2;
        q_exp.push_back({31'b0, e}); q_tag.push_back(t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        exp_rd(A_CTRL, 32'h20, "R1 ctrl");
        exp_rd(A_CNT,  32'h0,  "R1 count");
        exp_rd(A_LOAD, 32'h0,  "R1 load");
        exp_rd(A_RAW,  32'h0,  "R1 raw");
        exp_irq(1'b0, "R1 irq");
        // R2 layout, bit 4 and upper bits dropped
        wr(A_CTRL, 32'hFFFF_FFFF);
        exp_rd(A_CTRL, 32'hEF, "R2 ctrl readback");
        // R11 16-bit truncation
        wr(A_CTRL, 32'hE0);
        wr(A_LOAD, 32'h0001_2345);
        exp_rd(A_CNT, 32'h2345, "R11 count truncated");
        exp_rd(A_LOAD, 32'h0001_2345, "R11 load full");
        // R3 immediate load, 32-bit periodic div1
        wr(A_CTRL, 32'hE2);
        wr(A_LOAD, 32'd5);
        exp_rd(A_CNT, 32'd5, "R3 load immediate");
        ticks(2);
        exp_rd(A_CNT, 32'd3, "R2 two ticks");
        idle(3);
        exp_rd(A_CNT, 32'd3, "R2 no tick no change");
        // R4 background load
        wr(A_BG, 32'd10);
        exp_rd(A_CNT, 32'd3, "R4 count kept");
        exp_rd(A_LOAD, 32'd10, "R4 load at 0x00");
        exp_rd(A_BG, 32'd10, "R4 load at 0x18");
        // R5 periodic expiry
        ticks(3);
        exp_rd(A_CNT, 32'd10, "R5 periodic reload");
        exp_rd(A_RAW, 32'd1, "R7 raw set");
        exp_irq(1'b1, "R8 irq set");
        exp_rd(A_MIS, 32'd1, "R8 masked set");
        // R8 masking
        wr(A_CTRL, 32'hC2);
        exp_irq(1'b0, "R8 irq masked");
        exp_rd(A_MIS, 32'd0, "R8 masked status off");
        exp_rd(A_RAW, 32'd1, "R8 raw kept");
        wr(A_CTRL, 32'hE2);
        exp_irq(1'b1, "R8 irq unmasked");
        // R7 clear
        wr(A_ICLR, 32'h0);
        exp_rd(A_RAW, 32'd0, "R7 raw cleared");
        exp_irq(1'b0, "R7 irq cleared");
        // R9 ignored writes, zero reads
        wr(A_CNT, 32'h55);
        exp_rd(A_CNT, 32'd10, "R9 count write ignored");
        exp_rd(A_ICLR, 32'd0, "R9 clear reg reads 0");
        exp_rd(5'h1C, 32'd0, "R9 unmapped reads 0");
        exp_nord(A_LOAD, "R9 rdata 0 without rd_en");
        // R5 free-running wrap 16 and 32 bit
        wr(A_CTRL, 32'hA0);
        wr(A_LOAD, 32'd2);
        ticks(2);
        exp_rd(A_CNT, 32'h0000_FFFF, "R5 free wrap 16");
        exp_rd(A_RAW, 32'd1, "R5 free expiry raw");
        wr(A_ICLR, 32'h0);
        wr(A_CTRL, 32'hA2);
        wr(A_LOAD, 32'd1);
        ticks(1);
        exp_rd(A_CNT, 32'hFFFF_FFFF, "R5 free wrap 32");
        // R5 count 0 silent reload
        wr(A_CTRL, 32'hE2);
        wr(A_LOAD, 32'd0);
        wr(A_BG, 32'd7);
        wr(A_ICLR, 32'h0);
        ticks(1);
        exp_rd(A_CNT, 32'd7, "R5 reload from 0");
        exp_rd(A_RAW, 32'd0, "R5 no expiry from 0");
        // R6 one-shot
        wr(A_CTRL, 32'hA3);
        wr(A_LOAD, 32'd2);
        ticks(2);
        exp_rd(A_CNT, 32'd0, "R6 oneshot at 0");
        exp_rd(A_RAW, 32'd1, "R6 oneshot expiry");
        wr(A_ICLR, 32'h0);
        ticks(3);
        exp_rd(A_CNT, 32'd0, "R6 oneshot held");
        exp_rd(A_RAW, 32'd0, "R6 no second expiry");
        // R10 prescaler
        wr(A_CTRL, 32'hE6);
        wr(A_LOAD, 32'd100);
        ticks(15);
        exp_rd(A_CNT, 32'd100, "R10 div16 before 16th");
        ticks(1);
        exp_rd(A_CNT, 32'd99, "R10 div16 at 16th");
        wr(A_CTRL, 32'hEA);
        ticks(255);
        exp_rd(A_CNT, 32'd99, "R10 div256 before 256th");
        ticks(1);
        exp_rd(A_CNT, 32'd98, "R10 div256 at 256th");
        wr(A_CTRL, 32'hEE);
        ticks(1);
        exp_rd(A_CNT, 32'd97, "R10 code 11 divides by 1");
        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule